// File: doc/BRIEF.md
# Dual-Address Pass-Through Synchronous RAM

A synchronous storage array with two independent ports, X and Y. Each port has its own address, its own active-low write control and its own active-low pass-through control. Its 36-bit data path is split into an input vector and an output vector, and the output vector carries a valid flag. One rising clock edge captures every address, data word and control, together with the two chip enables. The next edge executes the captured request on both ports at once: reads, writes, or a hand-over of one port's input word to the other port's output. The result is visible right after that second edge.

When both ports name the same word, fixed rules resolve the clash. Two reads both return the stored word. A read paired with a write returns the contents from before the write. Two writes keep only the Y data. A pass-through aimed at a port replaces that port's array read. The output enables act combinationally. While a port's enable is high, the port presents a zero word and a cleared valid flag, which stands in for a floating bus.

The address width `AW` and data width `DW` are parameters. `AW = 15` gives the full 32,768-word array. The default of 10 keeps elaboration small.

Top module: `xy_pass_ram`

## Requirements
- R1: A request present before clock edge k is captured at edge k and executed at edge k+1, and its result appears on the outputs right after edge k+1 and not before.
- R2: With the chip selected, a port whose write control is 1 and which is not the target of a pass-through shows the word stored at its captured address, with the valid flag set.
- R3: The cycle is a deselect when `sel_n` is captured high or `sel` is captured low. A deselect cycle writes nothing. It clears both valid flags and leaves both output words unchanged.
- R4: A write control captured at 0 stores that port's input word at that port's address. Unless that port is a pass-through target, its valid flag clears and its output word stays unchanged.
- R5: `x_pass_n` captured at 0 places the X input word on the Y output, and `y_pass_n` captured at 0 places the Y input word on the X output, each with the valid flag set. Both may be active in the same cycle.
- R6: Pass-through has priority over read. A port targeted by a pass-through shows the passed word and not array data, even when it requests a read or a write.
- R7: Two reads of the same address in one cycle both return the stored word.
- R8: When one port writes an address and the other reads the same address in the same cycle, the read returns the contents from before the write.
- R9: When both ports write the same address in one cycle, only the Y input word is stored.
- R10: While a port's output enable is high, that port shows data 0 and valid 0 in the same cycle. Lowering the enable shows the held output register again.
- R11: A synchronous reset clears both output words and valid flags and cancels the captured request. The array contents survive the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_n | input | 1 | Chip enable, active low, captured |
| sel | input | 1 | Chip enable, active high, captured |
| x_addr | input | AW | Port X word address |
| x_din | input | DW | Port X input word |
| x_wr_n | input | 1 | Port X write (0) or read (1) |
| x_pass_n | input | 1 | 0 hands the X input word to the Y output |
| x_oe_n | input | 1 | Port X output enable, active low, combinational |
| x_dout | output | DW | Port X output word, 0 while disabled |
| x_dvalid | output | 1 | Port X output carries read or passed data |
| y_addr | input | AW | Port Y word address |
| y_din | input | DW | Port Y input word |
| y_wr_n | input | 1 | Port Y write (0) or read (1) |
| y_pass_n | input | 1 | 0 hands the Y input word to the X output |
| y_oe_n | input | 1 | Port Y output enable, active low, combinational |
| y_dout | output | DW | Port Y output word, 0 while disabled |
| y_dvalid | output | 1 | Port Y output carries read or passed data |

## Verification
The assertions check on every cycle the following behaviour. A pass-through beats any read. A deselect or a write clears the valid flag and leaves the output word unchanged. A read that collides with a write returns what the other port's array read returned before the write. Same-address reads agree. A disabled output floats to zero, and reset clears the output registers. Other behaviour only the bench's scenarios show, because it depends on the array's stored contents across cycles and on request order. That covers which word survives a double write and the ignored write of a deselected cycle. It also covers the data retained through reset and the exact two-edge latency.

// File: rtl/xy_ram_pkg.sv
package xy_ram_pkg;

  typedef enum logic [1:0] {
    SRC_HOLD  = 2'd0,
    SRC_ARRAY = 2'd1,
    SRC_PASS  = 2'd2
  } src_e;

  // chip is selected only with the low enable low and the high enable high
  function automatic logic chip_on(input logic en_lo, input logic en_hi);
    return ~en_lo & en_hi;
  endfunction

  // output source of one port: pass-through from the far port beats a read
  function automatic src_e route_src(input logic active, input logic own_wr_n,
                                     input logic far_pass_n);
    if (!active)          return SRC_HOLD;
    if (!far_pass_n)      return SRC_PASS;
    if (own_wr_n)         return SRC_ARRAY;
    return SRC_HOLD;
  endfunction

endpackage

// File: rtl/xy_in_stage.sv
module xy_in_stage #(
  parameter int AW = 10,
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          wr_n_i,
  input  logic          pass_n_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic          wr_n_o,
  output logic          pass_n_o
);

  always_ff @(posedge clk) begin
    addr_o <= addr_i;
    data_o <= data_i;
    if (rst) begin
      wr_n_o   <= 1'b1;
      pass_n_o <= 1'b1;
    end else begin
      wr_n_o   <= wr_n_i;
      pass_n_o <= pass_n_i;
    end
  end

endmodule

// File: rtl/xy_array.sv
module xy_array #(
  parameter int AW = 10,
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          we_a,
  input  logic [AW-1:0] addr_a,
  input  logic [DW-1:0] wdata_a,
  output logic [DW-1:0] rdata_a,
  input  logic          we_b,
  input  logic [AW-1:0] addr_b,
  input  logic [DW-1:0] wdata_b,
  output logic [DW-1:0] rdata_b
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  // reads see the array before this edge's writes
  assign rdata_a = store[addr_a];
  assign rdata_b = store[addr_b];

  // port b is written last so it wins on a shared address
  always_ff @(posedge clk) begin
    if (we_a) store[addr_a] <= wdata_a;
    if (we_b) store[addr_b] <= wdata_b;
  end

endmodule

// File: rtl/xy_out_stage.sv
module xy_out_stage
  import xy_ram_pkg::*;
#(
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst,
  input  src_e          src,
  input  logic [DW-1:0] arr_word,
  input  logic [DW-1:0] pass_word,
  output logic [DW-1:0] dq,
  output logic          vq
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dq <= '0;
      vq <= 1'b0;
    end else begin
      unique case (src)
        SRC_PASS: begin
          dq <= pass_word;
          vq <= 1'b1;
        end
        SRC_ARRAY: begin
          dq <= arr_word;
          vq <= 1'b1;
        end
        default: vq <= 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/xy_pass_ram.sv
module xy_pass_ram
  import xy_ram_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_n,
  input  logic          sel,
  input  logic [AW-1:0] x_addr,
  input  logic [DW-1:0] x_din,
  input  logic          x_wr_n,
  input  logic          x_pass_n,
  input  logic          x_oe_n,
  output logic [DW-1:0] x_dout,
  output logic          x_dvalid,
  input  logic [AW-1:0] y_addr,
  input  logic [DW-1:0] y_din,
  input  logic          y_wr_n,
  input  logic          y_pass_n,
  input  logic          y_oe_n,
  output logic [DW-1:0] y_dout,
  output logic          y_dvalid
);

  // captured request
  logic          act_q;
  logic [AW-1:0] xa_q, ya_q;
  logic [DW-1:0] xd_q, yd_q;
  logic          xw_q, xp_q, yw_q, yp_q;

  always_ff @(posedge clk) begin
    if (rst) act_q <= 1'b0;
    else     act_q <= chip_on(sel_n, sel);
  end

  xy_in_stage #(.AW(AW), .DW(DW)) u_in_x (
    .clk(clk), .rst(rst),
    .addr_i(x_addr), .data_i(x_din), .wr_n_i(x_wr_n), .pass_n_i(x_pass_n),
    .addr_o(xa_q), .data_o(xd_q), .wr_n_o(xw_q), .pass_n_o(xp_q)
  );

  xy_in_stage #(.AW(AW), .DW(DW)) u_in_y (
    .clk(clk), .rst(rst),
    .addr_i(y_addr), .data_i(y_din), .wr_n_i(y_wr_n), .pass_n_i(y_pass_n),
    .addr_o(ya_q), .data_o(yd_q), .wr_n_o(yw_q), .pass_n_o(yp_q)
  );

  // named events of the executing cycle
  logic x_wr_ev, y_wr_ev, x_rd_ev, y_rd_ev, x_pass_ev, y_pass_ev, same_addr;
  assign x_wr_ev   = act_q & ~xw_q;
  assign y_wr_ev   = act_q & ~yw_q;
  assign x_rd_ev   = act_q &  xw_q;
  assign y_rd_ev   = act_q &  yw_q;
  assign x_pass_ev = act_q & ~xp_q;   // X input toward Y output
  assign y_pass_ev = act_q & ~yp_q;   // Y input toward X output
  assign same_addr = (xa_q == ya_q);

  logic [DW-1:0] x_arr_word, y_arr_word;

  xy_array #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk),
    .we_a(x_wr_ev), .addr_a(xa_q), .wdata_a(xd_q), .rdata_a(x_arr_word),
    .we_b(y_wr_ev), .addr_b(ya_q), .wdata_b(yd_q), .rdata_b(y_arr_word)
  );

  src_e x_src, y_src;
  assign x_src = route_src(act_q, xw_q, yp_q);
  assign y_src = route_src(act_q, yw_q, xp_q);

  logic [DW-1:0] x_dq, y_dq;
  logic          x_vq, y_vq;

  xy_out_stage #(.DW(DW)) u_out_x (
    .clk(clk), .rst(rst), .src(x_src),
    .arr_word(x_arr_word), .pass_word(yd_q), .dq(x_dq), .vq(x_vq)
  );

  xy_out_stage #(.DW(DW)) u_out_y (
    .clk(clk), .rst(rst), .src(y_src),
    .arr_word(y_arr_word), .pass_word(xd_q), .dq(y_dq), .vq(y_vq)
  );

  // combinational output enables
  assign x_dout   = x_oe_n ? '0 : x_dq;
  assign x_dvalid = ~x_oe_n & x_vq;
  assign y_dout   = y_oe_n ? '0 : y_dq;
  assign y_dvalid = ~y_oe_n & y_vq;

endmodule

// File: rtl/xy_ram_checker.sv
module xy_ram_checker #(
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst,
  input logic          act_q,
  input logic          x_rd_ev,
  input logic          y_rd_ev,
  input logic          x_wr_ev,
  input logic          y_wr_ev,
  input logic          x_pass_ev,
  input logic          y_pass_ev,
  input logic          same_addr,
  input logic [DW-1:0] x_pass_word,
  input logic [DW-1:0] y_pass_word,
  input logic [DW-1:0] x_arr_word,
  input logic [DW-1:0] y_arr_word,
  input logic [DW-1:0] x_dq,
  input logic [DW-1:0] y_dq,
  input logic          x_vq,
  input logic          y_vq,
  input logic          x_oe_n,
  input logic          y_oe_n,
  input logic [DW-1:0] x_dout,
  input logic [DW-1:0] y_dout,
  input logic          x_dvalid,
  input logic          y_dvalid
);

  assert_reset_clear_R11: assert property (@(posedge clk)
    rst |=> !x_vq && !y_vq && x_dq == '0 && y_dq == '0);

  assert_deselect_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    !act_q |=> !x_vq && !y_vq && $stable(x_dq) && $stable(y_dq));

  assert_pass_to_x_R6: assert property (@(posedge clk) disable iff (rst)
    y_pass_ev |=> x_vq && x_dq == $past(y_pass_word));

  assert_pass_to_y_R6: assert property (@(posedge clk) disable iff (rst)
    x_pass_ev |=> y_vq && y_dq == $past(x_pass_word));

  assert_write_hold_x_R4: assert property (@(posedge clk) disable iff (rst)
    x_wr_ev && !y_pass_ev |=> !x_vq && $stable(x_dq));

  assert_write_hold_y_R4: assert property (@(posedge clk) disable iff (rst)
    y_wr_ev && !x_pass_ev |=> !y_vq && $stable(y_dq));

  assert_read_old_x_R8: assert property (@(posedge clk) disable iff (rst)
    x_rd_ev && !y_pass_ev && y_wr_ev && same_addr |=> x_dq == $past(y_arr_word));

  assert_read_old_y_R8: assert property (@(posedge clk) disable iff (rst)
    y_rd_ev && !x_pass_ev && x_wr_ev && same_addr |=> y_dq == $past(x_arr_word));

  assert_dual_read_R7: assert property (@(posedge clk) disable iff (rst)
    x_rd_ev && y_rd_ev && same_addr && !x_pass_ev && !y_pass_ev |=> x_dq == y_dq);

  assert_float_x_R10: assert property (@(posedge clk) disable iff (rst)
    x_oe_n |-> !x_dvalid && x_dout == '0);

  assert_float_y_R10: assert property (@(posedge clk) disable iff (rst)
    y_oe_n |-> !y_dvalid && y_dout == '0);

endmodule

bind xy_pass_ram xy_ram_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .act_q(act_q),
  .x_rd_ev(x_rd_ev), .y_rd_ev(y_rd_ev), .x_wr_ev(x_wr_ev), .y_wr_ev(y_wr_ev),
  .x_pass_ev(x_pass_ev), .y_pass_ev(y_pass_ev), .same_addr(same_addr),
  .x_pass_word(xd_q), .y_pass_word(yd_q),
  .x_arr_word(x_arr_word), .y_arr_word(y_arr_word),
  .x_dq(x_dq), .y_dq(y_dq), .x_vq(x_vq), .y_vq(y_vq),
  .x_oe_n(x_oe_n), .y_oe_n(y_oe_n), .x_dout(x_dout), .y_dout(y_dout),
  .x_dvalid(x_dvalid), .y_dvalid(y_dvalid)
);

// File: tb/sim_xy_pass_ram.sv
`timescale 1ns/1ps
module sim_xy_pass_ram;

  localparam int AW = 10;
  localparam int DW = 36;
  localparam int NV = 20;

  typedef struct packed {
    logic          sn;
    logic          s;
    logic          xw;
    logic          xp;
    logic [AW-1:0] xa;
    logic [DW-1:0] xd;
    logic          yw;
    logic          yp;
    logic [AW-1:0] ya;
    logic [DW-1:0] yd;
  } vec_t;

  // sn s | xw xp xa xd | yw yp ya yd
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b1, 1'b0,1'b1,10'd1,36'h1111, 1'b0,1'b1,10'd2,36'h2222},
    '{1'b0,1'b1, 1'b0,1'b1,10'd3,36'h3333, 1'b0,1'b1,10'd4,36'h4444},
    '{1'b0,1'b1, 1'b1,1'b1,10'd1,36'h0,    1'b1,1'b1,10'd2,36'h0},
    '{1'b0,1'b1, 1'b1,1'b1,10'd3,36'h0,    1'b1,1'b1,10'd3,36'h0},
    '{1'b0,1'b1, 1'b0,1'b1,10'd1,36'hAAAA, 1'b1,1'b1,10'd1,36'h0},
    '{1'b0,1'b1, 1'b1,1'b1,10'd1,36'h0,    1'b0,1'b1,10'd1,36'hBBBB},
    '{1'b0,1'b1, 1'b0,1'b1,10'd2,36'hC0C0, 1'b0,1'b1,10'd2,36'hD0D0},
    '{1'b0,1'b1, 1'b1,1'b1,10'd2,36'h0,    1'b1,1'b1,10'd2,36'h0},
    '{1'b0,1'b1, 1'b1,1'b0,10'd3,36'h5555, 1'b1,1'b1,10'd4,36'h0},
    '{1'b0,1'b1, 1'b1,1'b1,10'd4,36'h0,    1'b1,1'b0,10'd3,36'h6666},
    '{1'b0,1'b1, 1'b1,1'b0,10'd1,36'h7777, 1'b1,1'b0,10'd2,36'h8888},
    '{1'b1,1'b1, 1'b0,1'b1,10'd1,36'hEEEE, 1'b0,1'b1,10'd2,36'hEEEE},
    '{1'b0,1'b0, 1'b1,1'b0,10'd1,36'h9A9A, 1'b1,1'b0,10'd2,36'h9B9B},
    '{1'b0,1'b1, 1'b1,1'b1,10'd1,36'h0,    1'b1,1'b1,10'd2,36'h0},
    '{1'b0,1'b1, 1'b0,1'b1,10'd4,36'h9999, 1'b1,1'b0,10'd4,36'h1234},
    '{1'b0,1'b1, 1'b1,1'b1,10'd4,36'h0,    1'b1,1'b1,10'd4,36'h0},
    '{1'b0,1'b1, 1'b0,1'b0,10'd5,36'hF00D, 1'b1,1'b1,10'd6,36'h0},
    '{1'b0,1'b1, 1'b0,1'b1,10'd6,36'h6060, 1'b0,1'b1,10'd7,36'h7070},
    '{1'b0,1'b1, 1'b1,1'b1,10'd5,36'h0,    1'b1,1'b1,10'd7,36'h0},
    '{1'b0,1'b1, 1'b1,1'b1,10'd6,36'h0,    1'b1,1'b1,10'd3,36'h0}
  };

  logic          clk = 1'b0;
  logic          rst;
  logic          sel_n, sel;
  logic [AW-1:0] x_addr, y_addr;
  logic [DW-1:0] x_din, y_din;
  logic          x_wr_n, x_pass_n, x_oe_n, y_wr_n, y_pass_n, y_oe_n;
  logic [DW-1:0] x_dout, y_dout;
  logic          x_dvalid, y_dvalid;

  always #10 clk = ~clk;

  xy_pass_ram #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .sel_n(sel_n), .sel(sel),
    .x_addr(x_addr), .x_din(x_din), .x_wr_n(x_wr_n), .x_pass_n(x_pass_n),
    .x_oe_n(x_oe_n), .x_dout(x_dout), .x_dvalid(x_dvalid),
    .y_addr(y_addr), .y_din(y_din), .y_wr_n(y_wr_n), .y_pass_n(y_pass_n),
    .y_oe_n(y_oe_n), .y_dout(y_dout), .y_dvalid(y_dvalid)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // reference state
  logic [DW-1:0] ref_mem [1 << AW];
  logic [DW-1:0] ref_xd = '0, ref_yd = '0;
  logic          ref_xv = 1'b0, ref_yv = 1'b0;

  task automatic drive(input vec_t v);
    sel_n = v.sn; sel = v.s;
    x_wr_n = v.xw; x_pass_n = v.xp; x_addr = v.xa; x_din = v.xd;
    y_wr_n = v.yw; y_pass_n = v.yp; y_addr = v.ya; y_din = v.yd;
  endtask

  task automatic drive_idle();
    drive('{1'b1,1'b0, 1'b1,1'b1,10'd0,36'h0, 1'b1,1'b1,10'd0,36'h0});
  endtask

  // request semantics restated from the requirements
  task automatic ref_step(input vec_t v);
    bit on;
    on = !v.sn && v.s;
    if (!on) begin
      ref_xv = 0; ref_yv = 0;
    end else begin
      if (!v.yp)      begin ref_xd = v.yd;         ref_xv = 1; end
      else if (v.xw)  begin ref_xd = ref_mem[v.xa]; ref_xv = 1; end
      else                  ref_xv = 0;
      if (!v.xp)      begin ref_yd = v.xd;         ref_yv = 1; end
      else if (v.yw)  begin ref_yd = ref_mem[v.ya]; ref_yv = 1; end
      else                  ref_yv = 0;
      if (!v.xw) ref_mem[v.xa] = v.xd;
      if (!v.yw) ref_mem[v.ya] = v.yd;  // Y stored last: R9
    end
  endtask

  function automatic string tag_of(input vec_t v);
    if (v.sn || !v.s)                 return "R3";
    if (!v.xp || !v.yp)               return "R5/R6";
    if (v.xa == v.ya && v.xw && v.yw) return "R7";
    if (v.xa == v.ya && !v.xw && !v.yw) return "R9";
    if (v.xa == v.ya)                 return "R8";
    if (!v.xw || !v.yw)               return "R4";
    return "R2";
  endfunction

  task automatic check_ports(input string tag, input logic xv, input logic [DW-1:0] xd,
                             input logic yv, input logic [DW-1:0] yd);
    n_chk++;
    if (x_dvalid !== xv || x_dout !== xd || y_dvalid !== yv || y_dout !== yd) begin
      n_fail++;
      $display("FAIL %s: got X %b/%h Y %b/%h, expected X %b/%h Y %b/%h",
               tag, x_dvalid, x_dout, y_dvalid, y_dout, xv, xd, yv, yd);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got no end of run, expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; x_oe_n = 1'b0; y_oe_n = 1'b0;
    drive_idle();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state: R11
    check_ports("R11", 1'b0, '0, 1'b0, '0);

    // table walk: vector j driven at negedge j, result checked at negedge j+2 (R1)
    for (int j = 0; j < NV + 2; j++) begin
      if (j >= 2) begin
        ref_step(TBL[j-2]);
        check_ports(tag_of(TBL[j-2]), ref_xv, ref_xd, ref_yv, ref_yd);
      end
      if (j < NV) drive(TBL[j]); else drive_idle();
      @(negedge clk);
    end

    // R1: one edge after capture nothing is visible yet, after two it is
    drive('{1'b0,1'b1, 1'b1,1'b1,10'd3,36'h0, 1'b1,1'b1,10'd6,36'h0});
    @(negedge clk);
    drive_idle();
    check_ports("R1", 1'b0, ref_xd, 1'b0, ref_yd);
    @(negedge clk);
    check_ports("R1", 1'b1, 36'h3333, 1'b1, 36'h6060);

    // R10: output enables act in the same cycle and leave the register intact
    x_oe_n = 1'b1; #1;
    check_ports("R10", 1'b0, '0, 1'b1, 36'h6060);
    y_oe_n = 1'b1; #1;
    check_ports("R10", 1'b0, '0, 1'b0, '0);
    x_oe_n = 1'b0; y_oe_n = 1'b0; #1;
    check_ports("R10", 1'b1, 36'h3333, 1'b1, 36'h6060);

    // R11: reset clears outputs, a pending read is cancelled, memory survives
    drive('{1'b0,1'b1, 1'b1,1'b1,10'd1,36'h0, 1'b1,1'b1,10'd4,36'h0});
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    drive_idle();
    @(negedge clk);
    check_ports("R11", 1'b0, '0, 1'b0, '0);
    drive('{1'b0,1'b1, 1'b1,1'b1,10'd1,36'h0, 1'b1,1'b1,10'd4,36'h0});
    @(negedge clk);
    drive_idle();
    @(negedge clk);
    check_ports("R11", 1'b1, 36'hBBBB, 1'b1, 36'h9999);

    finish_run();
  end

endmodule